// File: doc/BRIEF.md
# Flash lock-bit command controller

This block is a small register-mapped sequencer for the protection state of an embedded flash. It keeps a bank of lock bits, one per flash region, and a short bank of general-purpose configuration bits. Both banks live in flip-flops and stand in for non-volatile cells. Software drives the block through four word registers: mode, command, status and result.

A command word carries a protection keyword, an argument and an opcode. A command whose keyword or opcode is wrong does not run, and it raises an error flag instead. An accepted command drops the ready flag. It then waits out a fixed busy time, applies its effect and raises ready again. The get-lock command rewinds a read pointer. Reads of the result register then return the lock bits 32 at a time and return zero once the last word has been read. Reads of the flash array are granted at all times, including while a command is busy.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset, ready is 1, the error flag is 0, the ready-interrupt enable is 0, `irq` is 0, and every lock bit and configuration bit is 0.
- R2: The command register is at address 1. Its layout is keyword in bits 31:24, argument in bits 23:8 and opcode in bits 7:0, and the valid keyword is 0x5A. A valid command clears ready on the write edge and sets ready again exactly BUSY_CYCLES clock edges later. A command write while ready is 0 is ignored.
- R3: A command write with a keyword other than 0x5A, or with an opcode outside 0x08..0x0C, changes no bit and sets the error flag (status bit 1, at address 2). A read of the status register clears that flag. Ready is status bit 0.
- R4: Opcode 0x08 sets the lock bit selected by the argument, and opcode 0x09 clears it. No other lock bit changes.
- R5: A set-lock or clear-lock command whose argument is at or above NUM_LOCK still completes, and it changes no lock bit.
- R6: Opcode 0x0A rewinds the result pointer. Each read of the result register (address 3) then returns the next 32 lock bits, starting with bits 31:0. Bit n of the stream is 1 exactly when region n is locked.
- R7: A read of the result register after the last implemented lock word returns 0.
- R8: The mode register (address 0) bit 0 enables the ready interrupt. `irq` is 1 exactly when that bit and ready are both 1.
- R9: Opcode 0x0B sets the configuration bit selected by the argument, and opcode 0x0C clears it. These bits appear on `cfg_bits`, do not affect the lock bits, and an argument at or above NUM_CFG changes nothing.
- R10: `arr_gnt` follows `arr_req` in every cycle, including while a command is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status and result reads have side effects) |
| bus_addr | input | 2 | Register select: 0 mode, 1 command, 2 status, 3 result |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Ready interrupt |
| cfg_bits | output | NUM_CFG | Configuration bits |
| arr_req | input | 1 | Flash array read request |
| arr_gnt | output | 1 | Flash array read grant |

## Verification
The bench targets the range edges. These are lock bit 63 and bit 64 when there are 64 lock bits, and configuration bit 2 and bit 3 when there are three. A design with an off-by-one in the range check would lock a phantom region, or would wrap the argument and hit bit 0. The bench also reads a third result word, which must be zero. It reads the result register again after a fresh get-lock command, which catches a design that never rewinds its pointer. It times the ready rise by the edge, so a busy counter that is one edge early or late shows up. Finally, it sends wrong-key and unknown-opcode commands and a status read after each, which catches an error flag that never sets, never clears, or lets the command run anyway.

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl #(
  parameter int NUM_LOCK    = 64,
  parameter int NUM_CFG     = 3,
  parameter int BUSY_CYCLES = 4,
  parameter logic [7:0] KEY = 8'h5A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq,
  output logic [NUM_CFG-1:0] cfg_bits,
  input  logic               arr_req,
  output logic               arr_gnt
);
  localparam int NW  = (NUM_LOCK + 31) / 32;
  localparam int PW  = $clog2(NW + 1);
  localparam int LW  = (NUM_LOCK > 1) ? $clog2(NUM_LOCK) : 1;
  localparam int CW  = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;
  localparam int TW  = $clog2(BUSY_CYCLES + 1);
  localparam logic [PW-1:0] NW_P   = PW'(NW);
  localparam logic [15:0]   LOCK16 = 16'(NUM_LOCK);
  localparam logic [15:0]   CFG16  = 16'(NUM_CFG);
  localparam logic [1:0] A_MODE = 2'd0, A_CMD = 2'd1, A_STAT = 2'd2, A_RES = 2'd3;
  localparam logic [7:0] OP_SLB = 8'h08, OP_CLB = 8'h09, OP_GLB = 8'h0A,
                         OP_SCB = 8'h0B, OP_CCB = 8'h0C;

  logic [NUM_LOCK-1:0] lock_q;
  logic [NUM_CFG-1:0]  cfg_q;
  logic [NW*32-1:0]    lock_pad;
  logic [PW-1:0]       ptr;
  logic [TW-1:0]       cnt;
  logic [7:0]          op_q;
  logic [15:0]         arg_q;
  logic                ready, err, irq_en;
  logic [31:0]         res_word;

  wire busy    = cnt != '0;
  wire done    = cnt == TW'(1);
  wire cmd_wr  = bus_wr && bus_addr == A_CMD && !busy;
  wire key_ok  = bus_wdata[31:24] == KEY;
  wire op_ok   = bus_wdata[7:0] >= OP_SLB && bus_wdata[7:0] <= OP_CCB;
  wire lock_in = arg_q < LOCK16;
  wire cfg_in  = arg_q < CFG16;
  wire [LW-1:0] lidx = arg_q[LW-1:0];
  wire [CW-1:0] cidx = arg_q[CW-1:0];

  always_comb begin
    lock_pad = '0;
    lock_pad[NUM_LOCK-1:0] = lock_q;
  end

  assign res_word = (ptr < NW_P) ? lock_pad[int'(ptr)*32 +: 32] : 32'd0;

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = {31'd0, irq_en};
      A_STAT:  bus_rdata = {30'd0, err, ready};
      A_RES:   bus_rdata = res_word;
      default: bus_rdata = 32'd0;
    endcase
  end

  assign irq      = irq_en & ready;
  assign cfg_bits = cfg_q;
  assign arr_gnt  = arr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      cfg_q  <= '0;
      ptr    <= '0;
      cnt    <= '0;
      op_q   <= '0;
      arg_q  <= '0;
      ready  <= 1'b1;
      err    <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_MODE) irq_en <= bus_wdata[0];
      if (bus_rd && bus_addr == A_STAT) err <= 1'b0;
      if (bus_rd && bus_addr == A_RES && ptr < NW_P) ptr <= ptr + 1'b1;
      if (cmd_wr) begin
        if (key_ok && op_ok) begin
          op_q  <= bus_wdata[7:0];
          arg_q <= bus_wdata[23:8];
          cnt   <= TW'(BUSY_CYCLES);
          ready <= 1'b0;
          ptr   <= '0;
        end else begin
          err <= 1'b1;
        end
      end else if (busy) begin
        cnt <= cnt - 1'b1;
        if (done) begin
          ready <= 1'b1;
          case (op_q)
            OP_SLB: if (lock_in) lock_q[lidx] <= 1'b1;
            OP_CLB: if (lock_in) lock_q[lidx] <= 1'b0;
            OP_SCB: if (cfg_in)  cfg_q[cidx]  <= 1'b1;
            OP_CCB: if (cfg_in)  cfg_q[cidx]  <= 1'b0;
            OP_GLB: ;
            default: ;
          endcase
        end
      end
    end
  end

  p_reset_ready_r1: assert property (@(posedge clk) $rose(rst_n) |-> ready && !err);

  p_busy_clears_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && key_ok && op_ok) |=> !ready && busy);

  p_done_raises_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready && !busy);

  p_bad_cmd_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !(key_ok && op_ok)) |=> err && $stable(lock_q) && $stable(cfg_q));

  p_locks_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(lock_q));

  p_single_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $countones(lock_q ^ $past(lock_q)) <= 1);

  p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !lock_in) |=> $stable(lock_q));

  p_tail_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_RES && ptr >= NW_P) |-> bus_rdata == 32'd0);

  p_irq_needs_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !irq);

  p_cfg_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_in) |=> $stable(cfg_q));
endmodule

// File: tb/flash_lock_ctrl_test.sv
module flash_lock_ctrl_test;
  localparam int BUSY = 4;
  localparam int NV = 12;
  localparam logic [7:0] K = 8'h5A;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, arr_req = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, arr_gnt;
  logic [2:0] cfg_bits;
  int checks = 0, errors = 0, cyc = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  flash_lock_ctrl #(.NUM_LOCK(64), .NUM_CFG(3), .BUSY_CYCLES(BUSY), .KEY(K)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cfg_bits(cfg_bits),
    .arr_req(arr_req), .arr_gnt(arr_gnt));

  function automatic logic [31:0] cw(input logic [7:0] key, input logic [15:0] arg, input logic [7:0] op);
    return {key, arg, op};
  endfunction

  // {command, word0, word1, cfg}
  localparam logic [98:0] VEC [NV] = '{
    {32'h5A000308, 32'h00000008, 32'h00000000, 3'b000},
    {32'h5A002808, 32'h00000008, 32'h00000100, 3'b000},
    {32'h5A003F08, 32'h00000008, 32'h80000100, 3'b000},
    {32'h5A004008, 32'h00000008, 32'h80000100, 3'b000},
    {32'h5A000309, 32'h00000000, 32'h80000100, 3'b000},
    {32'h5A00020B, 32'h00000000, 32'h80000100, 3'b100},
    {32'h5A00030B, 32'h00000000, 32'h80000100, 3'b100},
    {32'h5A000008, 32'h00000001, 32'h80000100, 3'b100},
    {32'h5A00020C, 32'h00000001, 32'h80000100, 3'b000},
    {32'h5A006309, 32'h00000001, 32'h80000100, 3'b000},
    {32'h5A00000B, 32'h00000001, 32'h80000100, 3'b001},
    {32'h5A003F09, 32'h00000001, 32'h00000100, 3'b001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic cmd(input logic [31:0] w);
    logic [31:0] s;
    wr(2'd1, w);
    for (int i = 0; i < 50; i++) begin
      rd(2'd2, s);
      if (s[0]) break;
    end
  endtask

  task automatic glb(output logic [31:0] w0, output logic [31:0] w1, output logic [31:0] w2);
    cmd(cw(K, 16'd0, 8'h0A));
    rd(2'd3, w0); rd(2'd3, w1); rd(2'd3, w2);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d, w0, w1, w2;
    logic [98:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(2'd2, d); chk("R1 status", d, 32'h1);
    rd(2'd0, d); chk("R1 mode", d, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 cfg", {29'd0, cfg_bits}, 32'd0);
    glb(w0, w1, w2);
    chk("R1 lock w0", w0, 0); chk("R1 lock w1", w1, 0);

    // R4 R5 R6 R7 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      cmd(v[98:67]);
      glb(w0, w1, w2);
      chk("R4/R5 R6 word0", w0, v[66:35]);
      chk("R4/R5 R6 word1", w1, v[34:3]);
      chk("R7 tail word", w2, 32'd0);
      chk("R9 cfg", {29'd0, cfg_bits}, {29'd0, v[2:0]});
    end
    rd(2'd3, d); chk("R7 repeat tail", d, 32'd0);

    // R2 R8 R10 timing of ready and irq
    wr(2'd0, 32'h1);
    chk("R8 irq enabled idle", {31'd0, irq}, 32'd1);
    arr_req = 1;
    wr(2'd1, cw(K, 16'd7, 8'h08));
    chk("R2 ready low after write", {31'd0, irq}, 32'd0);
    chk("R10 grant while busy", {31'd0, arr_gnt}, 32'd1);
    wr(2'd1, cw(K, 16'd9, 8'h08));
    for (int i = 0; i < BUSY - 3; i++) @(negedge clk);
    chk("R2 still busy", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R2 ready after busy", {31'd0, irq}, 32'd1);
    arr_req = 0; #1;
    chk("R10 grant follows", {31'd0, arr_gnt}, 32'd0);
    wr(2'd0, 32'h0);
    chk("R8 irq disabled", {31'd0, irq}, 32'd0);
    glb(w0, w1, w2);
    chk("R2 busy write ignored", w0, 32'h00000081);

    // R3 wrong key and bad opcode
    wr(2'd1, cw(8'h33, 16'd5, 8'h08));
    rd(2'd2, d); chk("R3 bad key err", d, 32'h3);
    rd(2'd2, d); chk("R3 err cleared", d, 32'h1);
    wr(2'd1, cw(K, 16'd1, 8'h0F));
    rd(2'd2, d); chk("R3 bad op err", d, 32'h3);
    wr(2'd1, cw(8'h00, 16'd1, 8'h0B));
    rd(2'd2, d); chk("R3 bad key cfg err", d, 32'h3);
    chk("R3 cfg unchanged", {29'd0, cfg_bits}, 32'h1);
    glb(w0, w1, w2);
    chk("R3 locks unchanged", w0, 32'h00000081);

    // R6 pointer rewinds on new get-lock
    cmd(cw(K, 16'd0, 8'h0A));
    rd(2'd3, d);
    cmd(cw(K, 16'd0, 8'h0A));
    rd(2'd3, d); chk("R6 rewind", d, 32'h00000081);
    rd(2'd3, d); chk("R6 second word", d, 32'h00000100);

    finish_run();
  end
endmodule